// File: doc/BRIEF.md
# Aligned Burst Chopper and Flitizer

This block takes one memory transaction at a time, given as a start address, a byte length and an interleave granularity code. It cuts the transaction into sub-transactions whose boundaries fall on fixed, aligned address multiples of a chop size. Each piece's address, byte length and 16-byte flit count go out on a valid/ready interface. The chop size is 256 bytes. The one exception is a granularity finer than 256 bytes, where the chop size drops to that granularity. Because the cuts follow address alignment and not a running byte count, the first and last pieces can be shorter than the chop size.

A transaction is accepted only while the block is idle. The block then emits its pieces in ascending address order and flags the final one. It becomes ready again in the cycle after the final piece's handshake. Flit counts include the start address offset within a 16-byte flit, so a piece that straddles flit boundaries is charged for every flit it touches.

Top module: `addr_chop_flitizer`

## Requirements
- R1: While reset is held, and after it is released, `out_valid` is 0 and `in_ready` is 1 until a transaction is accepted.
- R2: `in_ready` is 0 from the cycle after a non-empty transaction is accepted until its final piece is handed off. While `in_ready` is 0, `in_valid` and the input fields have no effect on the output pieces.
- R3: The chop size is 256 bytes for `in_gran` code 0 (not interleaved) and for codes 2 to 6 (256 B, 512 B, 1 KB, 2 KB and 4 KB granularity). Reserved code 7 also gives 256 bytes.
- R4: For `in_gran` code 1 (128 B granularity), the chop size is 128 bytes.
- R5: The first piece starts at `in_addr`. Each following piece starts where the previous one ended. Every piece except the last ends on a chop-size-aligned address. The piece lengths add up to `in_len`.
- R6: `out_flits` equals ceil((`out_addr` mod 16 + `out_len`) / 16).
- R7: `out_last` is 1 on the final piece only. `in_ready` returns to 1 in the cycle after that piece's handshake.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value on the next cycle.
- R9: A transaction with `in_len` of 0 is accepted and produces no piece. `in_ready` stays 1.
- R10: With 256-byte chopping, 1024 bytes from address 0 give four pieces, and 1024 bytes from address 128 give five pieces: 128–255, then 256-byte pieces up to 1024–1151.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Transaction request valid |
| in_ready | output | 1 | Block idle and able to take a transaction |
| in_addr | input | ADDR_W | Transaction start byte address |
| in_len | input | LEN_W | Transaction byte length |
| in_gran | input | 3 | Granularity code: 0 none, 1..6 = 128 B..4 KB, 7 reserved |
| out_valid | output | 1 | Piece valid |
| out_ready | input | 1 | Downstream accepts the piece |
| out_addr | output | ADDR_W | Piece start byte address |
| out_len | output | PIECE_W | Piece byte length (1..256) |
| out_flits | output | FLIT_W | Number of 16-byte flits the piece occupies |
| out_last | output | 1 | Final piece of the transaction |

## Verification
The bench sweeps start offsets on both sides of the 128-byte and 256-byte lines, together with lengths from 1 byte up to several chops, under every granularity code.

Each class of error shows up differently:
- A chopper that cuts fixed-size chunks from the start address would give an unaligned second piece.
- One that ignores the 128-byte code would give 256-byte pieces where 128-byte pieces are expected.
- Dropping the in-flit offset from the flit count would undercount pieces that start mid-flit and cross a flit line.
- Mishandling a zero length would hang the block busy or emit a stray piece.

Stalls on `out_ready` and junk requests driven while the block is busy expose pieces that drift under backpressure, or a second transaction that leaks in.

// File: rtl/chop_pkg.sv
package chop_pkg;

  localparam int FLIT_LOG2 = 4;

  typedef enum logic [2:0] {
    GRAN_NONE = 3'd0,
    GRAN_128  = 3'd1,
    GRAN_256  = 3'd2,
    GRAN_512  = 3'd3,
    GRAN_1K   = 3'd4,
    GRAN_2K   = 3'd5,
    GRAN_4K   = 3'd6,
    GRAN_RSVD = 3'd7
  } gran_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } chop_state_e;

endpackage

// File: rtl/chop_rst_sync.sv
module chop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/chop_size_dec.sv
module chop_size_dec
  import chop_pkg::*;
#(
  parameter int BASE_CHOP_LOG2 = 8,
  parameter int MIN_GRAN_LOG2  = 7,
  parameter int LOG_W          = 4
) (
  input  gran_e            gran,
  output logic [LOG_W-1:0] chop_log2
);

  int gran_log2;

  always_comb begin
    gran_log2 = MIN_GRAN_LOG2 + int'(gran) - 1;
    chop_log2 = LOG_W'(BASE_CHOP_LOG2);
    if (gran != GRAN_NONE && gran != GRAN_RSVD) begin
      if (gran_log2 < BASE_CHOP_LOG2) begin
        chop_log2 = LOG_W'(gran_log2);
      end
    end
  end

endmodule

// File: rtl/chop_piece_calc.sv
module chop_piece_calc
  import chop_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int LOG_W   = 4,
  parameter int PIECE_W = 9,
  parameter int FLIT_W  = 5
) (
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [LEN_W-1:0]   remain,
  input  logic [LOG_W-1:0]   chop_log2,
  output logic [PIECE_W-1:0] piece_len,
  output logic [FLIT_W-1:0]  piece_flits,
  output logic               piece_last
);

  localparam int FLIT_BYTES = 1 << FLIT_LOG2;

  logic [PIECE_W-1:0] chop_bytes;
  logic [PIECE_W-1:0] offset;
  logic [PIECE_W-1:0] to_bound;
  logic [PIECE_W:0]   span;

  always_comb begin
    chop_bytes = PIECE_W'(1) << chop_log2;
    offset     = cur_addr[PIECE_W-1:0] & (chop_bytes - PIECE_W'(1));
    to_bound   = chop_bytes - offset;
    if (remain <= LEN_W'(to_bound)) begin
      piece_last = 1'b1;
      piece_len  = remain[PIECE_W-1:0];
    end else begin
      piece_last = 1'b0;
      piece_len  = to_bound;
    end
    span = {1'b0, piece_len}
         + (PIECE_W+1)'(cur_addr[FLIT_LOG2-1:0])
         + (PIECE_W+1)'(FLIT_BYTES - 1);
    piece_flits = FLIT_W'(span >> FLIT_LOG2);
  end

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int LOG_W   = 4,
  parameter int PIECE_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [LEN_W-1:0]   in_len,
  input  logic [LOG_W-1:0]   in_chop_log2,
  input  logic               out_ready,
  input  logic [PIECE_W-1:0] piece_len,
  input  logic               piece_last,
  output logic               busy,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [LEN_W-1:0]   remain,
  output logic [LOG_W-1:0]   chop_log2
);

  chop_state_e       state_q, state_d;
  logic              load, advance;
  logic              addr_en, rem_en, log_en;
  logic [ADDR_W-1:0] addr_d;
  logic [LEN_W-1:0]  rem_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    advance = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          load    = 1'b1;
          state_d = (in_len != '0) ? ST_EMIT : ST_IDLE;
        end
      end
      ST_EMIT: begin
        if (out_ready) begin
          if (piece_last) begin
            state_d = ST_IDLE;
          end else begin
            advance = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    addr_en = load | advance;
    rem_en  = load | advance;
    log_en  = load;
    addr_d  = load ? in_addr : (cur_addr + ADDR_W'(piece_len));
    rem_d   = load ? in_len  : (remain - LEN_W'(piece_len));
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_addr  <= '0;
      remain    <= '0;
      chop_log2 <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) cur_addr  <= addr_d;
      if (rem_en)  remain    <= rem_d;
      if (log_en)  chop_log2 <= in_chop_log2;
    end
  end

  assign busy = (state_q == ST_EMIT);

endmodule

// File: rtl/addr_chop_flitizer.sv
module addr_chop_flitizer
  import chop_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 16,
  parameter int BASE_CHOP_LOG2 = 8,
  parameter int MIN_GRAN_LOG2  = 7,
  localparam int LOG_W         = 4,
  localparam int PIECE_W       = BASE_CHOP_LOG2 + 1,
  localparam int FLIT_W        = BASE_CHOP_LOG2 - FLIT_LOG2 + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [LEN_W-1:0]   in_len,
  input  logic [2:0]         in_gran,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [PIECE_W-1:0] out_len,
  output logic [FLIT_W-1:0]  out_flits,
  output logic               out_last
);

  logic               rst_n_int;
  logic [LOG_W-1:0]   dec_log2;
  logic [LOG_W-1:0]   cur_log2;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   remain;
  logic [PIECE_W-1:0] piece_len;
  logic [FLIT_W-1:0]  piece_flits;
  logic               piece_last;
  logic               busy;

  chop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  chop_size_dec #(
    .BASE_CHOP_LOG2 (BASE_CHOP_LOG2),
    .MIN_GRAN_LOG2  (MIN_GRAN_LOG2),
    .LOG_W          (LOG_W)
  ) u_dec (
    .gran      (gran_e'(in_gran)),
    .chop_log2 (dec_log2)
  );

  chop_ctrl #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .LOG_W   (LOG_W),
    .PIECE_W (PIECE_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .in_valid     (in_valid),
    .in_addr      (in_addr),
    .in_len       (in_len),
    .in_chop_log2 (dec_log2),
    .out_ready    (out_ready),
    .piece_len    (piece_len),
    .piece_last   (piece_last),
    .busy         (busy),
    .cur_addr     (cur_addr),
    .remain       (remain),
    .chop_log2    (cur_log2)
  );

  chop_piece_calc #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .LOG_W   (LOG_W),
    .PIECE_W (PIECE_W),
    .FLIT_W  (FLIT_W)
  ) u_calc (
    .cur_addr    (cur_addr),
    .remain      (remain),
    .chop_log2   (cur_log2),
    .piece_len   (piece_len),
    .piece_flits (piece_flits),
    .piece_last  (piece_last)
  );

  assign in_ready  = ~busy;
  assign out_valid = busy;
  assign out_addr  = cur_addr;
  assign out_len   = piece_len;
  assign out_flits = piece_flits;
  assign out_last  = piece_last;

endmodule

// File: rtl/addr_chop_flitizer_chk.sv
module addr_chop_flitizer_chk #(
  parameter int ADDR_W        = 32,
  parameter int PIECE_W       = 9,
  parameter int FLIT_W        = 5,
  parameter int MIN_CHOP_LOG2 = 7,
  parameter int MAX_FLITS     = 16,
  parameter int MAX_PIECE     = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [ADDR_W-1:0]  out_addr,
  input logic [PIECE_W-1:0] out_len,
  input logic [FLIT_W-1:0]  out_flits,
  input logic               out_last
);

  logic [ADDR_W-1:0] end_addr;
  assign end_addr = out_addr + ADDR_W'(out_len);

  // R2
  busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_len)
       && $stable(out_flits) && $stable(out_last)));

  // R5
  aligned_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (end_addr[MIN_CHOP_LOG2-1:0] == '0));

  // R5
  contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_addr == $past(end_addr)));

  // R5
  piece_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0 && int'(out_len) <= MAX_PIECE));

  // R6
  flit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flits != '0 && int'(out_flits) <= MAX_FLITS));

  // R7
  last_frees_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> in_ready);

endmodule

bind addr_chop_flitizer addr_chop_flitizer_chk #(
  .ADDR_W        (ADDR_W),
  .PIECE_W       (PIECE_W),
  .FLIT_W        (FLIT_W),
  .MIN_CHOP_LOG2 ((MIN_GRAN_LOG2 < BASE_CHOP_LOG2) ? MIN_GRAN_LOG2 : BASE_CHOP_LOG2),
  .MAX_FLITS     (1 << (BASE_CHOP_LOG2 - 4)),
  .MAX_PIECE     (1 << BASE_CHOP_LOG2)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_len   (out_len),
  .out_flits (out_flits),
  .out_last  (out_last)
);

// File: tb/addr_chop_flitizer_tb_top.sv
`timescale 1ns/1ps
module addr_chop_flitizer_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_addr;
  logic [15:0] in_len;
  logic [2:0]  in_gran;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_addr;
  logic [8:0]  out_len;
  logic [4:0]  out_flits;
  logic        out_last;

  int tests_run;
  int tests_failed;
  bit finished;

  addr_chop_flitizer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_addr   (in_addr),
    .in_len    (in_len),
    .in_gran   (in_gran),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_len   (out_len),
    .out_flits (out_flits),
    .out_last  (out_last)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint pack_piece(input logic [31:0] a, input logic [8:0] l,
                                        input logic [4:0] f, input logic last);
    return {17'd0, a, l, f, last};
  endfunction

  // Runs one transaction; returns number of pieces observed.
  task automatic run_txn(input logic [31:0] a, input logic [15:0] l, input logic [2:0] g,
                         input int stall_mod, input bit junk, output int npieces);
    logic [31:0] ea;
    logic [15:0] rem;
    int          chop, off, tb, pl, fl, idx;
    bit          lst;
    longint      expv, actv;
    npieces = 0;
    @(negedge clk);
    check(in_ready === 1'b1, "R7 idle before request", in_ready, 1);
    in_valid = 1'b1; in_addr = a; in_len = l; in_gran = g;
    @(negedge clk);
    in_valid = junk;
    in_addr  = 32'hDEAD_BEE0; in_len = 16'd999; in_gran = 3'd1;
    if (l == 0) begin
      check(out_valid === 1'b0 && in_ready === 1'b1, "R9 zero length", {out_valid, in_ready}, 2'b01);
    end else begin
      check(in_ready === 1'b0, "R2 busy after accept", in_ready, 0);
    end
    ea = a; rem = l; idx = 0;
    chop = (g == 3'd1) ? 128 : 256; // R3 R4
    while (rem != 0) begin
      off = int'(ea) & (chop - 1);
      tb  = chop - off;
      pl  = (int'(rem) < tb) ? int'(rem) : tb;
      fl  = ((int'(ea) & 15) + pl + 15) / 16;
      lst = (int'(rem) == pl);
      expv = pack_piece(ea, 9'(pl), 5'(fl), lst);
      if (stall_mod != 0 && (idx % stall_mod) == 0) begin
        out_ready = 1'b0;
        actv = pack_piece(out_addr, out_len, out_flits, out_last);
        @(negedge clk);
        check(out_valid === 1'b1 && pack_piece(out_addr, out_len, out_flits, out_last) == actv,
              "R8 hold under stall", pack_piece(out_addr, out_len, out_flits, out_last), actv);
      end
      actv = pack_piece(out_addr, out_len, out_flits, out_last);
      check(out_valid === 1'b1 && actv == expv, "R5 R6 R7 piece", actv, expv);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      npieces++;
      idx++;
      ea  = ea + 32'(pl);
      rem = rem - 16'(pl);
      if (npieces > 600) break;
    end
    in_valid = 1'b0;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R7 R2 idle after last",
          {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    int np;
    tests_run = 0; tests_failed = 0; finished = 0;
    in_valid = 0; in_addr = 0; in_len = 0; in_gran = 0; out_ready = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 during reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 after reset", {out_valid, in_ready}, 2'b01);

    // R10 worked examples
    run_txn(32'd0, 16'd1024, 3'd0, 0, 0, np);
    check(np == 4, "R10 four pieces from 0", np, 4);
    run_txn(32'd128, 16'd1024, 3'd0, 0, 0, np);
    check(np == 5, "R10 five pieces from 128", np, 5);
    run_txn(32'd0, 16'd1024, 3'd1, 0, 0, np);
    check(np == 8, "R4 eight 128-byte pieces", np, 8);
    run_txn(32'd300, 16'd0, 3'd2, 0, 0, np);
    check(np == 0, "R9 no piece", np, 0);

    // sweep: all granularity codes, offsets around lines, many lengths (R3 R4 R5 R6 R8 R2)
    for (int g = 0; g < 8; g++) begin
      for (int ai = 0; ai < 10; ai++) begin
        for (int li = 0; li < 24; li++) begin
          logic [31:0] a;
          logic [15:0] l;
          a = 32'h0001_0000 + 32'(ai * 29 + ((ai % 3) * 120));
          l = 16'(li * 37 + (li % 4));
          run_txn(a, l, 3'(g), (li % 3) + 1, (li % 2) == 1, np);
        end
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule